// File: doc/BRIEF.md
# Address-Decoded Burst Bus Controller

This block models a small shared bus with one requesting master and two responding slaves. On a start pulse the master loads its own base address as the source and a target address into the bus registers, then raises the busy flag. An address decoder compares the target against each slave's window. The selected slave writes a fixed four-beat burst into the shared data buffer, one beat per cycle, and then sets the lock flag. When the master sees lock, it reads the four beats out in consecutive cycles. It then clears busy and lock together and advances its transaction counter.

By default the master alternates its target between the two slaves by the parity of the counter. A test input can override the target with any address. If no slave answers, a wait timer expires after a fixed number of intervals. The master then drops busy, waits out a backoff period and reissues the same transaction on its own. Transactions never overlap, so bursts always complete in issue order.

Master states: `M_IDLE`, `M_WAIT`, `M_COLLECT`, `M_RELEASE`, `M_ABORT`, `M_BACKOFF`.

Master transitions:
- M_IDLE to M_WAIT on a start pulse or a pending retry.
- M_WAIT to M_COLLECT when lock is set and the source address lies in the master's window.
- M_WAIT to M_ABORT when the wait timer expires.
- M_COLLECT to M_RELEASE after the last beat.
- M_RELEASE to M_IDLE.
- M_ABORT to M_BACKOFF.
- M_BACKOFF to M_IDLE when the backoff count ends.

Slave states: `S_IDLE`, `S_FILL`, `S_HOLD`.

Slave transitions:
- S_IDLE to S_FILL when busy is set and the slave is selected.
- S_FILL to S_HOLD after the last beat is written.
- S_HOLD to S_IDLE once busy falls.

Top module: `bbus_ctrl`

## Requirements
- R1: After reset, `bus_busy`, `bus_lock`, `rx_valid`, `rx_done` and `wait_timeout` are 0, and `txn_count` is 0.
- R2: With no override, the master targets address 0x100 when `txn_count` is even and 0x200 when it is odd. Every beat reports the target on `rx_tgt`.
- R3: The slave at 0x100–0x1FF delivers beat i as 10+i. The slave at 0x200–0x2FF delivers beat i as 100+i.
- R4: Each burst delivers exactly 4 beats on consecutive cycles with `rx_beat` counting 0,1,2,3. Beat 0 appears 6 cycles after the clock edge that samples `go`. Lock is set for the whole burst.
- R5: `bus_busy` is set from the edge that samples `go`. `bus_lock` is never set without `bus_busy`.
- R6: The cycle after the last beat, `rx_done` pulses for one cycle. At the next edge busy and lock clear and `txn_count` rises by exactly 1. `txn_count` changes at no other time.
- R7: Window edges are inclusive. Target 0x1FF reaches the first slave and 0x2FF the second. 0x0FF and 0x300 reach no slave.
- R8: A target outside both slave windows produces no lock and no beats. `wait_timeout` pulses 40 cycles after the issuing edge (10 intervals of 4 cycles). Busy then clears and `txn_count` is unchanged.
- R9: After a timeout, the master reissues automatically after an 8-cycle backoff. Beat 0 of the retry appears 56 cycles after the original issuing edge. The retry's target is chosen at reissue.
- R10: A `go` pulse while a transaction is in progress is ignored. It starts no further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start one transaction when the master is idle |
| force_tgt_en | input | 1 | Use `force_tgt_addr` as the target at issue |
| force_tgt_addr | input | ADDR_W | Override target address |
| bus_busy | output | 1 | Bus busy flag |
| bus_lock | output | 1 | Burst-ready lock flag |
| txn_count | output | CNT_W | Completed transaction counter |
| rx_valid | output | 1 | A received beat is presented |
| rx_beat | output | BEAT_W | Index of the presented beat |
| rx_data | output | DATA_W | Value of the presented beat |
| rx_tgt | output | ADDR_W | Target address of the current transaction |
| rx_done | output | 1 | One-cycle pulse at transaction completion |
| wait_timeout | output | 1 | One-cycle pulse when the wait for lock expires |

## Verification
Beat 0 is due 6 cycles after the edge that samples `go`, and beats 1 to 3 follow on consecutive cycles. The done pulse comes the cycle after beat 3, and the counter and flag updates one edge after that. A timeout is due 40 cycles after issue, and a retry's first beat 56 cycles after issue. The driver records the edge number at which it raises `go` and stores the cycle at which beat 0 must arrive. The scoreboard monitor samples on falling edges and compares the arrival cycle, target, index and value of each popped beat. The counter and flag checks are taken on the falling edge one cycle after the done or timeout pulse.

// File: rtl/bbus_pkg.sv
package bbus_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_WAIT,
        M_COLLECT,
        M_RELEASE,
        M_ABORT,
        M_BACKOFF
    } mst_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FILL,
        S_HOLD
    } slv_state_t;

endpackage

// File: rtl/bbus_decoder.sv
module bbus_decoder #(
    parameter int ADDR_W  = 16,
    parameter int NUM_SLV = 2,
    parameter logic [NUM_SLV*ADDR_W-1:0] SLV_LO = '0,
    parameter logic [NUM_SLV*ADDR_W-1:0] SLV_HI = '0
) (
    input  logic [ADDR_W-1:0]  tgt,
    output logic [NUM_SLV-1:0] sel
);
    // One window comparator per slave; windows are inclusive at both ends.
    for (genvar g = 0; g < NUM_SLV; g++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = SLV_LO[g*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HI = SLV_HI[g*ADDR_W +: ADDR_W];
        assign sel[g] = (tgt >= LO) && (tgt <= HI);
    end
endmodule

// File: rtl/bbus_slave.sv
module bbus_slave
    import bbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BEATS  = 4,
    parameter logic [DATA_W-1:0] FILL_BASE = '0,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              hit,
    output logic              wr_en,
    output logic [BEAT_W-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              lock_set
);
    slv_state_t  state, state_nx;
    logic [BEAT_W-1:0] cnt;
    logic        last;

    assign last = (cnt == BEAT_W'(BEATS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (busy && hit) state_nx = S_FILL;
            S_FILL:  if (last)        state_nx = S_HOLD;
            S_HOLD:  if (!busy)       state_nx = S_IDLE;
            default:                  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (state != S_FILL) cnt <= '0;
        else                     cnt <= last ? '0 : cnt + 1'b1;
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        lock_set = 1'b0;
        wr_idx   = cnt;
        wr_data  = FILL_BASE + DATA_W'(cnt);
        unique case (state)
            S_FILL: begin
                wr_en    = 1'b1;
                lock_set = last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bbus_fabric.sv
module bbus_fabric #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int BEATS   = 4,
    parameter int NUM_SLV = 2,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue,
    input  logic [ADDR_W-1:0]         issue_src,
    input  logic [ADDR_W-1:0]         issue_tgt,
    input  logic                      release_bus,
    input  logic [NUM_SLV-1:0]        wr_en,
    input  logic [NUM_SLV*BEAT_W-1:0] wr_idx,
    input  logic [NUM_SLV*DATA_W-1:0] wr_data,
    input  logic [NUM_SLV-1:0]        lock_set,
    input  logic [BEAT_W-1:0]         rd_idx,
    output logic                      busy,
    output logic                      lock,
    output logic [ADDR_W-1:0]         src,
    output logic [ADDR_W-1:0]         tgt,
    output logic [DATA_W-1:0]         rd_data
);
    logic [DATA_W-1:0] buffer [BEATS];
    logic              any_wr;
    logic [BEAT_W-1:0] w_idx;
    logic [DATA_W-1:0] w_dat;

    // merge of the slave write ports; at most one slave is selected
    always_comb begin
        any_wr = 1'b0;
        w_idx  = '0;
        w_dat  = '0;
        for (int s = 0; s < NUM_SLV; s++) begin
            if (wr_en[s]) begin
                any_wr = 1'b1;
                w_idx  = w_idx | wr_idx[s*BEAT_W +: BEAT_W];
                w_dat  = w_dat | wr_data[s*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            lock <= 1'b0;
            src  <= '0;
            tgt  <= '0;
        end else begin
            if (issue) begin
                busy <= 1'b1;
                src  <= issue_src;
                tgt  <= issue_tgt;
            end else if (release_bus) begin
                busy <= 1'b0;
            end
            if (release_bus)    lock <= 1'b0;
            else if (|lock_set) lock <= 1'b1;
        end
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)                               buffer[b] <= '0;
            else if (any_wr && w_idx == BEAT_W'(b))   buffer[b] <= w_dat;
        end
    end

    assign rd_data = buffer[rd_idx];
endmodule

// File: rtl/bbus_master.sv
module bbus_master
    import bbus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BEATS       = 4,
    parameter int CNT_W       = 8,
    parameter int WAIT_LIMIT  = 10,
    parameter int TICK_CYC    = 4,
    parameter int BACKOFF_CYC = 8,
    parameter logic [ADDR_W-1:0] MST_LO  = 16'h0300,
    parameter logic [ADDR_W-1:0] MST_HI  = 16'h03FF,
    parameter logic [ADDR_W-1:0] EVEN_TGT = 16'h0100,
    parameter logic [ADDR_W-1:0] ODD_TGT  = 16'h0200,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int PRE_W  = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1,
    localparam int IVL_W  = $clog2(WAIT_LIMIT + 1),
    localparam int BO_W   = (BACKOFF_CYC > 1) ? $clog2(BACKOFF_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              force_en,
    input  logic [ADDR_W-1:0] force_addr,
    input  logic              bus_lock,
    input  logic [ADDR_W-1:0] bus_src,
    input  logic [ADDR_W-1:0] bus_tgt,
    input  logic [DATA_W-1:0] rd_data,
    output logic              issue,
    output logic [ADDR_W-1:0] issue_src,
    output logic [ADDR_W-1:0] issue_tgt,
    output logic              release_bus,
    output logic [BEAT_W-1:0] rd_idx,
    output logic              rx_valid,
    output logic [BEAT_W-1:0] rx_beat,
    output logic [DATA_W-1:0] rx_data,
    output logic [ADDR_W-1:0] rx_tgt,
    output logic              rx_done,
    output logic              wait_timeout,
    output logic [CNT_W-1:0]  txn_count
);
    mst_state_t state, state_nx;

    logic [BEAT_W-1:0] idx;
    logic [PRE_W-1:0]  pre;
    logic [IVL_W-1:0]  ivl;
    logic [BO_W-1:0]   bo;
    logic              retry_pend;
    logic              src_ok, last_beat, tick, expired, bo_end, start;

    assign src_ok    = (bus_src >= MST_LO) && (bus_src <= MST_HI);
    assign last_beat = (idx == BEAT_W'(BEATS - 1));
    assign tick      = (pre == PRE_W'(TICK_CYC - 1));
    assign expired   = tick && (ivl == IVL_W'(WAIT_LIMIT - 1));
    assign bo_end    = (bo == BO_W'(BACKOFF_CYC - 1));
    assign start     = go || retry_pend;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            M_IDLE:    if (start) state_nx = M_WAIT;
            M_WAIT: begin
                if (bus_lock && src_ok) state_nx = M_COLLECT;
                else if (expired)       state_nx = M_ABORT;
            end
            M_COLLECT: if (last_beat) state_nx = M_RELEASE;
            M_RELEASE:                state_nx = M_IDLE;
            M_ABORT:                  state_nx = M_BACKOFF;
            M_BACKOFF: if (bo_end)    state_nx = M_IDLE;
            default:                  state_nx = M_IDLE;
        endcase
    end

    // counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            pre        <= '0;
            ivl        <= '0;
            bo         <= '0;
            retry_pend <= 1'b0;
            txn_count  <= '0;
        end else begin
            if (state == M_COLLECT) idx <= last_beat ? '0 : idx + 1'b1;
            else                    idx <= '0;

            if (state == M_WAIT) begin
                pre <= tick ? '0 : pre + 1'b1;
                if (tick) ivl <= ivl + 1'b1;
            end else begin
                pre <= '0;
                ivl <= '0;
            end

            if (state == M_BACKOFF) bo <= bo + 1'b1;
            else                    bo <= '0;

            if (state == M_ABORT)                   retry_pend <= 1'b1;
            else if (state == M_IDLE && start)      retry_pend <= 1'b0;

            if (state == M_RELEASE) txn_count <= txn_count + 1'b1;
        end
    end

    // outputs
    always_comb begin
        issue        = 1'b0;
        release_bus  = 1'b0;
        rx_valid     = 1'b0;
        rx_done      = 1'b0;
        wait_timeout = 1'b0;
        issue_src    = MST_LO;
        issue_tgt    = force_en ? force_addr : (txn_count[0] ? ODD_TGT : EVEN_TGT);
        rd_idx       = idx;
        rx_beat      = idx;
        rx_data      = rd_data;
        rx_tgt       = bus_tgt;
        unique case (state)
            M_IDLE:    issue = start;
            M_COLLECT: rx_valid = 1'b1;
            M_RELEASE: begin
                rx_done     = 1'b1;
                release_bus = 1'b1;
            end
            M_ABORT: begin
                wait_timeout = 1'b1;
                release_bus  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bbus_ctrl.sv
module bbus_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BEATS       = 4,
    parameter int CNT_W       = 8,
    parameter int WAIT_LIMIT  = 10,
    parameter int TICK_CYC    = 4,
    parameter int BACKOFF_CYC = 8,
    parameter logic [ADDR_W-1:0] MST_LO = 16'h0300,
    parameter logic [ADDR_W-1:0] MST_HI = 16'h03FF,
    parameter logic [2*ADDR_W-1:0] SLV_LO   = {16'h0200, 16'h0100},
    parameter logic [2*ADDR_W-1:0] SLV_HI   = {16'h02FF, 16'h01FF},
    parameter logic [2*DATA_W-1:0] SLV_FILL = {16'd100, 16'd10},
    localparam int NUM_SLV = 2,
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              force_tgt_en,
    input  logic [ADDR_W-1:0] force_tgt_addr,
    output logic              bus_busy,
    output logic              bus_lock,
    output logic [CNT_W-1:0]  txn_count,
    output logic              rx_valid,
    output logic [BEAT_W-1:0] rx_beat,
    output logic [DATA_W-1:0] rx_data,
    output logic [ADDR_W-1:0] rx_tgt,
    output logic              rx_done,
    output logic              wait_timeout
);
    logic                      issue, release_bus;
    logic [ADDR_W-1:0]         issue_src, issue_tgt, bus_src, bus_tgt;
    logic [BEAT_W-1:0]         rd_idx;
    logic [DATA_W-1:0]         rd_data;
    logic [NUM_SLV-1:0]        sel, wr_en, lock_set;
    logic [NUM_SLV*BEAT_W-1:0] wr_idx;
    logic [NUM_SLV*DATA_W-1:0] wr_data;

    bbus_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .CNT_W(CNT_W),
        .WAIT_LIMIT(WAIT_LIMIT), .TICK_CYC(TICK_CYC), .BACKOFF_CYC(BACKOFF_CYC),
        .MST_LO(MST_LO), .MST_HI(MST_HI),
        .EVEN_TGT(SLV_LO[0 +: ADDR_W]), .ODD_TGT(SLV_LO[ADDR_W +: ADDR_W])
    ) u_master (
        .clk(clk), .rst_n(rst_n), .go(go),
        .force_en(force_tgt_en), .force_addr(force_tgt_addr),
        .bus_lock(bus_lock), .bus_src(bus_src), .bus_tgt(bus_tgt), .rd_data(rd_data),
        .issue(issue), .issue_src(issue_src), .issue_tgt(issue_tgt),
        .release_bus(release_bus), .rd_idx(rd_idx),
        .rx_valid(rx_valid), .rx_beat(rx_beat), .rx_data(rx_data), .rx_tgt(rx_tgt),
        .rx_done(rx_done), .wait_timeout(wait_timeout), .txn_count(txn_count)
    );

    bbus_fabric #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .NUM_SLV(NUM_SLV)
    ) u_fabric (
        .clk(clk), .rst_n(rst_n),
        .issue(issue), .issue_src(issue_src), .issue_tgt(issue_tgt),
        .release_bus(release_bus),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .lock_set(lock_set),
        .rd_idx(rd_idx),
        .busy(bus_busy), .lock(bus_lock), .src(bus_src), .tgt(bus_tgt),
        .rd_data(rd_data)
    );

    bbus_decoder #(
        .ADDR_W(ADDR_W), .NUM_SLV(NUM_SLV), .SLV_LO(SLV_LO), .SLV_HI(SLV_HI)
    ) u_dec (
        .tgt(bus_tgt), .sel(sel)
    );

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_slv
        bbus_slave #(
            .DATA_W(DATA_W), .BEATS(BEATS),
            .FILL_BASE(SLV_FILL[g*DATA_W +: DATA_W])
        ) u_slv (
            .clk(clk), .rst_n(rst_n),
            .busy(bus_busy), .hit(sel[g]),
            .wr_en(wr_en[g]),
            .wr_idx(wr_idx[g*BEAT_W +: BEAT_W]),
            .wr_data(wr_data[g*DATA_W +: DATA_W]),
            .lock_set(lock_set[g])
        );
    end
endmodule

// File: rtl/bbus_ctrl_chk.sv
module bbus_ctrl_chk #(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_busy,
    input logic              bus_lock,
    input logic [CNT_W-1:0]  txn_count,
    input logic              rx_valid,
    input logic [BEAT_W-1:0] rx_beat,
    input logic              rx_done,
    input logic              wait_timeout
);
    p_lock_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> bus_busy);

    p_beat_under_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> bus_lock);

    p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_beat != BEAT_W'(BEATS - 1))
        |=> (rx_valid && rx_beat == BEAT_W'($past(rx_beat) + 1'b1)));

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_beat == BEAT_W'(BEATS - 1)) |=> rx_done);

    p_release_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (!bus_busy && !bus_lock));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (txn_count == CNT_W'($past(txn_count) + 1'b1)));

    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(txn_count));

    p_timeout_nolock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_timeout |-> (!bus_lock && !rx_valid));

    p_timeout_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_timeout |=> !bus_busy);
endmodule

bind bbus_ctrl bbus_ctrl_chk #(
    .BEATS(BEATS), .BEAT_W(BEAT_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .bus_lock(bus_lock),
    .txn_count(txn_count), .rx_valid(rx_valid), .rx_beat(rx_beat),
    .rx_done(rx_done), .wait_timeout(wait_timeout)
);

// File: tb/bbus_ctrl_tb.sv
module bbus_ctrl_tb;
    localparam int LAT_FIRST = 6;
    localparam int T_OUT     = 40;
    localparam int BACKOFF   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        force_tgt_en = 1'b0;
    logic [15:0] force_tgt_addr = '0;
    logic        bus_busy, bus_lock, rx_valid, rx_done, wait_timeout;
    logic [7:0]  txn_count;
    logic [1:0]  rx_beat;
    logic [15:0] rx_data, rx_tgt;

    typedef struct {
        logic [15:0] tgt;
        logic [1:0]  beat;
        logic [15:0] data;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int first_cyc = 0;
    string cur_req = "R3";
    bit wd_hit = 0;

    always #10ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bbus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .go(go),
        .force_tgt_en(force_tgt_en), .force_tgt_addr(force_tgt_addr),
        .bus_busy(bus_busy), .bus_lock(bus_lock), .txn_count(txn_count),
        .rx_valid(rx_valid), .rx_beat(rx_beat), .rx_data(rx_data),
        .rx_tgt(rx_tgt), .rx_done(rx_done), .wait_timeout(wait_timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare every beat the design presents
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R10", "unexpected beat", int'(rx_beat), -1);
            end else begin
                item_t it;
                it = q.pop_front();
                check(rx_tgt == it.tgt, "R2", "target", int'(rx_tgt), int'(it.tgt));
                check(rx_beat == it.beat, "R4", "beat index", int'(rx_beat), int'(it.beat));
                check(rx_data == it.data, cur_req, "beat value", int'(rx_data), int'(it.data));
                if (it.beat == 2'd0)
                    check(cyc == first_cyc, "R4", "first beat cycle", cyc, first_cyc);
            end
        end
    end

    task automatic push_burst(input logic [15:0] tgt, input logic [15:0] base);
        for (int i = 0; i < 4; i++) begin
            item_t it;
            it.tgt  = tgt;
            it.beat = 2'(i);
            it.data = base + 16'(i);
            q.push_back(it);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!rx_done && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_txn(input logic [15:0] tgt, input logic [15:0] base,
                           input string req, input bit poke_go);
        int cnt0;
        cnt0 = int'(txn_count);
        cur_req = req;
        push_burst(tgt, base);
        @(negedge clk);
        go = 1'b1;
        first_cyc = cyc + 1 + LAT_FIRST;
        @(negedge clk);
        go = 1'b0;
        check(bus_busy == 1'b1, "R5", "busy after go", int'(bus_busy), 1);
        if (poke_go) begin
            repeat (2) @(negedge clk);
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        wait_done();
        check(rx_done == 1'b1, "R6", "done pulse", int'(rx_done), 1);
        @(negedge clk);
        check(!bus_busy && !bus_lock, "R6", "flags cleared", int'({bus_busy, bus_lock}), 0);
        check(int'(txn_count) == cnt0 + 1, "R6", "count step", int'(txn_count), cnt0 + 1);
        check(q.size() == 0, "R4", "all beats seen", q.size(), 0);
    endtask

    task automatic run_timeout(input logic [15:0] bad, input logic [15:0] rtgt,
                               input logic [15:0] rbase);
        int cnt0, go_at, n;
        cnt0 = int'(txn_count);
        force_tgt_en = 1'b1;
        force_tgt_addr = bad;
        @(negedge clk);
        go = 1'b1;
        go_at = cyc + 1;
        @(negedge clk);
        go = 1'b0;
        n = 0;
        while (!wait_timeout && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(wait_timeout == 1'b1, "R8", "timeout seen", int'(wait_timeout), 1);
        check(cyc == go_at + T_OUT, "R8", "timeout cycle", cyc, go_at + T_OUT);
        check(bus_lock == 1'b0, "R7", "no slave answered", int'(bus_lock), 0);
        force_tgt_en = 1'b0;
        cur_req = "R9";
        push_burst(rtgt, rbase);
        first_cyc = go_at + T_OUT + 2 + BACKOFF + LAT_FIRST;
        @(negedge clk);
        check(bus_busy == 1'b0, "R8", "busy dropped", int'(bus_busy), 0);
        check(int'(txn_count) == cnt0, "R8", "count unchanged", int'(txn_count), cnt0);
        wait_done();
        check(rx_done == 1'b1, "R9", "retry done", int'(rx_done), 1);
        @(negedge clk);
        check(int'(txn_count) == cnt0 + 1, "R9", "retry count", int'(txn_count), cnt0 + 1);
        check(q.size() == 0, "R9", "retry beats seen", q.size(), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R1 reset state
                check(!bus_busy && !bus_lock, "R1", "flags in reset", int'({bus_busy, bus_lock}), 0);
                check(txn_count == 8'd0, "R1", "count in reset", int'(txn_count), 0);
                check(!rx_valid && !rx_done && !wait_timeout, "R1", "pulses in reset",
                      int'({rx_valid, rx_done, wait_timeout}), 0);
                rst_n = 1'b1;
                repeat (2) @(negedge clk);
                check(!bus_busy && txn_count == 8'd0, "R1", "idle after reset",
                      int'({bus_busy, txn_count}), 0);

                run_txn(16'h0100, 16'd10,  "R3", 1'b0);   // count 0 -> slave one
                run_txn(16'h0200, 16'd100, "R3", 1'b0);   // count 1 -> slave two
                run_txn(16'h0100, 16'd10,  "R10", 1'b1);  // stray go mid-burst
                repeat (20) @(negedge clk);
                check(bus_busy == 1'b0, "R10", "stray go ignored", int'(bus_busy), 0);
                run_txn(16'h0200, 16'd100, "R2", 1'b0);

                // window edges R7
                force_tgt_en = 1'b1;
                force_tgt_addr = 16'h01FF;
                run_txn(16'h01FF, 16'd10, "R7", 1'b0);
                force_tgt_addr = 16'h02FF;
                run_txn(16'h02FF, 16'd100, "R7", 1'b0);
                force_tgt_en = 1'b0;

                // misses R8 / R9: count 6 then 7
                run_timeout(16'h00FF, 16'h0100, 16'd10);
                run_timeout(16'h0300, 16'h0200, 16'd100);
                check(txn_count == 8'd8, "R6", "final count", int'(txn_count), 8);
            end
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule